// File: doc/BRIEF.md
# Parallel Converter Readout Sequencer

This block is the host-side master for an external successive-approximation converter with a parallel bus. When the host raises a conversion request, the block drives the active-low conversion start line for a set time. It then watches the converter's busy line. The line must go high, and later low again. After that the block runs chip-select/read cycles to fetch the result. It presents the result, the channel number reported by the converter, and a one-cycle valid strobe.

The same bus also carries configuration writes. A 12-bit control word is written in one strobe when the bus is in word mode. In byte mode it takes two strobes, and the block itself drives the byte-select line. Every timing limit is a parameter in picoseconds. At elaboration the block turns each one into host clock cycles, rounding up. Two more parameters set the busy-wait timeout and the result width: a 12-bit result, or a 10-bit result that drops the two zero LSBs.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is low and after it is released, conv_start_n, bus_cs_n, bus_rd_n and bus_wr_n are high, byte_hi_sel, bus_oe, res_valid and timeout_err are low, bus_dout is zero and ready is high.
- R2: When conv_req is sampled high while ready is high, conv_start_n goes low in the next cycle and stays low for ceil(CONV_LOW_PS/CLK_PS) cycles; ready is low from that cycle until the transaction ends.
- R3: After conv_start_n rises, no read begins until cnv_busy has been sampled high and later sampled low. In the cycle after cnv_busy is sampled low, bus_cs_n falls. It stays low for ceil(SETUP_PS/CLK_PS) cycles (at least 1) before bus_rd_n falls.
- R4: bus_rd_n is low for exactly ceil(STROBE_PS/CLK_PS) cycles, only while bus_cs_n is low. Data is sampled on the last edge of the strobe, and bus_cs_n and bus_rd_n then rise together.
- R5: With word_mode = 1, a single read is made. res_data is bus_din[11:0], res_chan is 0, and res_valid is high for exactly the one cycle after the strobe ends.
- R6: With word_mode = 0, two reads are made. The first has byte_hi_sel = 0, and bus_din[7:0] gives result bits 7:0. The second has byte_hi_sel = 1: bus_din[3:0] gives result bits 11:8 and bus_din[6:4] gives the channel. bus_din[11:7] is ignored in byte mode. bus_cs_n is high for ceil(GAP_PS/CLK_PS) cycles between the two reads. byte_hi_sel is stable from chip-select fall until after the strobe rises.
- R7: After the last read, ready returns high (and byte_hi_sel returns low) ceil(QUIET_PS/CLK_PS) cycles later. A new conversion start cannot happen earlier.
- R8: With RESULT_BITS = 10, res_data is result bits 11:2.
- R9: If the busy handshake is not complete within BUSY_TMO_CYC cycles of conv_start_n rising, timeout_err pulses for one cycle at that count. ready returns high in the same cycle and no read is made.
- R10: When cfg_wr_req is sampled high while ready is high and conv_req is low, the word is latched. In word mode, bus_oe is high and bus_dout = cfg_wr_word from chip-select fall to the end of the gap. One bus_wr_n strobe of the strobe length follows the setup time, and ready returns after the gap.
- R11: In byte mode a write makes two strobes: first bus_dout = {4'h0, word[7:0]} with byte_hi_sel = 0, then bus_dout = {8'h00, word[11:8]} with byte_hi_sel = 1. This keeps bits 7:4 of the high byte at zero.
- R12: conv_req and cfg_wr_req are ignored while ready is low. When both are sampled high together in the ready state, the conversion is started and the write is dropped.
- R13: Each picosecond limit becomes a cycle count by rounding up, with a floor of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | input | 1 | Request a conversion and readout |
| cfg_wr_req | input | 1 | Request a control-word write |
| cfg_wr_word | input | 12 | Control word to write |
| word_mode | input | 1 | 1 = 12-bit word transfers, 0 = two byte transfers |
| cnv_busy | input | 1 | Converter busy flag, synchronous to clk |
| bus_din | input | 12 | Data read from the converter bus |
| bus_dout | output | 12 | Data driven onto the converter bus |
| bus_oe | output | 1 | Output enable for bus_dout |
| conv_start_n | output | 1 | Active-low conversion start |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| byte_hi_sel | output | 1 | High-byte select in byte mode |
| ready | output | 1 | Idle and able to accept a request |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RESULT_BITS | Conversion result |
| res_chan | output | 3 | Channel number of the result |
| timeout_err | output | 1 | One-cycle busy-timeout flag |

## Verification
The bench builds two instances side by side on the same bus: a 12-bit one and a 10-bit one. This shows that both the full and the truncated result paths format the same read data. The timing parameters are set off the 5 ns grid: 12 ns start, 0 ns setup, 30 ns strobe, 10 ns gap and 11 ns quiet. With these values the rounding gives 3, 1, 6, 2 and 3 cycles, and the zero setup time lands on the one-cycle floor. The busy timeout is set to 16 cycles. This makes both the "busy never rises" and the "busy never falls" paths quick to reach, next to handshakes that finish well inside the limit.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int RAW_BITS  = 12;
    localparam int CHAN_BITS = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CNV,
        S_WAIT_HI,
        S_WAIT_LO,
        S_RSU,
        S_RSTB,
        S_RGAP,
        S_QUIET,
        S_WSU,
        S_WSTB,
        S_WGAP
    } seq_state_t;

    // time in ps -> clock cycles, rounded up, never below one
    function automatic int cyc_ceil(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_host_fmt.sv
module adc_host_fmt
    import adc_host_pkg::*;
#(
    parameter int RESULT_BITS = 12
) (
    input  logic                   word_mode,
    input  logic [7:0]             lo_byte,
    input  logic [RAW_BITS-1:0]    bus,
    output logic [RESULT_BITS-1:0] res,
    output logic [CHAN_BITS-1:0]   chan
);

    logic [RAW_BITS-1:0] raw;

    always_comb begin
        raw  = word_mode ? bus : {bus[3:0], lo_byte};
        chan = word_mode ? '0 : bus[6:4];
    end

    generate
        if (RESULT_BITS == RAW_BITS) begin : g_full
            assign res = raw;
        end else begin : g_trunc
            assign res = raw[RAW_BITS-1 -: RESULT_BITS];
        end
    endgenerate

endmodule

// File: rtl/adc_host_wdog.sv
module adc_host_wdog #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expire
);

    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en)
            cnt_d = '0;
        else if (cnt_q != W'(LIMIT))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
        expire = en && (cnt_q >= W'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int CLK_PS       = 5000,
    parameter int CONV_LOW_PS  = 10000,
    parameter int SETUP_PS     = 5000,
    parameter int STROBE_PS    = 30000,
    parameter int GAP_PS       = 10000,
    parameter int QUIET_PS     = 50000,
    parameter int BUSY_TMO_CYC = 2048,
    parameter int RESULT_BITS  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv_req,
    input  logic                   cfg_wr_req,
    input  logic [11:0]            cfg_wr_word,
    input  logic                   word_mode,
    input  logic                   cnv_busy,
    input  logic [11:0]            bus_din,
    output logic [11:0]            bus_dout,
    output logic                   bus_oe,
    output logic                   conv_start_n,
    output logic                   bus_cs_n,
    output logic                   bus_rd_n,
    output logic                   bus_wr_n,
    output logic                   byte_hi_sel,
    output logic                   ready,
    output logic                   res_valid,
    output logic [RESULT_BITS-1:0] res_data,
    output logic [2:0]             res_chan,
    output logic                   timeout_err
);

    localparam int CNV_CYC   = cyc_ceil(CONV_LOW_PS, CLK_PS);
    localparam int SU_CYC    = cyc_ceil(SETUP_PS, CLK_PS);
    localparam int STB_CYC   = cyc_ceil(STROBE_PS, CLK_PS);
    localparam int GAP_CYC   = cyc_ceil(GAP_PS, CLK_PS);
    localparam int QUIET_CYC = cyc_ceil(QUIET_PS, CLK_PS);
    localparam int MAX_CYC   = imax(imax(CNV_CYC, SU_CYC),
                                    imax(imax(STB_CYC, GAP_CYC), QUIET_CYC));
    localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        seq_state_t              state;
        logic [CNT_W-1:0]        cnt;
        logic                    word;
        logic                    second;
        logic [RAW_BITS-1:0]     wdat;
        logic [7:0]              lo;
        logic                    cvn;
        logic                    csn;
        logic                    rdn;
        logic                    wrn;
        logic                    hsel;
        logic                    oe;
        logic [RAW_BITS-1:0]     dout;
        logic                    vld;
        logic [RESULT_BITS-1:0]  res;
        logic [CHAN_BITS-1:0]    chan;
        logic                    err;
        logic                    rdy;
    } ctrl_t;

    localparam ctrl_t RST_VAL = '{
        state: S_IDLE, cnt: '0, word: 1'b0, second: 1'b0, wdat: '0, lo: '0,
        cvn: 1'b1, csn: 1'b1, rdn: 1'b1, wrn: 1'b1, hsel: 1'b0, oe: 1'b0,
        dout: '0, vld: 1'b0, res: '0, chan: '0, err: 1'b0, rdy: 1'b1
    };

    ctrl_t d, q;

    logic                   wd_en;
    logic                   wd_expire;
    logic [RESULT_BITS-1:0] fmt_res;
    logic [CHAN_BITS-1:0]   fmt_chan;

    assign wd_en = (q.state == S_WAIT_HI) || (q.state == S_WAIT_LO);

    adc_host_wdog #(.LIMIT(BUSY_TMO_CYC)) i_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (wd_en),
        .expire (wd_expire)
    );

    adc_host_fmt #(.RESULT_BITS(RESULT_BITS)) i_fmt (
        .word_mode (q.word),
        .lo_byte   (q.lo),
        .bus       (bus_din),
        .res       (fmt_res),
        .chan      (fmt_chan)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.err = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (conv_req) begin
                    d.state  = S_CNV;
                    d.cnt    = CNT_W'(CNV_CYC - 1);
                    d.cvn    = 1'b0;
                    d.rdy    = 1'b0;
                    d.word   = word_mode;
                    d.second = 1'b0;
                end else if (cfg_wr_req) begin
                    d.state  = S_WSU;
                    d.cnt    = CNT_W'(SU_CYC - 1);
                    d.csn    = 1'b0;
                    d.hsel   = 1'b0;
                    d.oe     = 1'b1;
                    d.dout   = word_mode ? cfg_wr_word : {4'h0, cfg_wr_word[7:0]};
                    d.wdat   = cfg_wr_word;
                    d.word   = word_mode;
                    d.second = 1'b0;
                    d.rdy    = 1'b0;
                end
            end
            S_CNV: begin
                if (q.cnt == '0) begin
                    d.cvn   = 1'b1;
                    d.state = S_WAIT_HI;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_WAIT_HI, S_WAIT_LO: begin
                if (q.state == S_WAIT_HI && cnv_busy) begin
                    d.state = S_WAIT_LO;
                end else if (q.state == S_WAIT_LO && !cnv_busy) begin
                    d.state = S_RSU;
                    d.cnt   = CNT_W'(SU_CYC - 1);
                    d.csn   = 1'b0;
                    d.hsel  = 1'b0;
                end else if (wd_expire) begin
                    d.state = S_IDLE;
                    d.err   = 1'b1;
                    d.rdy   = 1'b1;
                end
            end
            S_RSU: begin
                if (q.cnt == '0) begin
                    d.rdn   = 1'b0;
                    d.state = S_RSTB;
                    d.cnt   = CNT_W'(STB_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_RSTB: begin
                if (q.cnt == '0) begin
                    d.rdn = 1'b1;
                    d.csn = 1'b1;
                    if (!q.word && !q.second) begin
                        d.lo     = bus_din[7:0];
                        d.second = 1'b1;
                        d.state  = S_RGAP;
                        d.cnt    = CNT_W'(GAP_CYC - 1);
                    end else begin
                        d.vld   = 1'b1;
                        d.res   = fmt_res;
                        d.chan  = fmt_chan;
                        d.state = S_QUIET;
                        d.cnt   = CNT_W'(QUIET_CYC - 1);
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_RGAP: begin
                if (q.cnt == '0) begin
                    d.state = S_RSU;
                    d.cnt   = CNT_W'(SU_CYC - 1);
                    d.csn   = 1'b0;
                    d.hsel  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_QUIET: begin
                if (q.cnt == '0) begin
                    d.state = S_IDLE;
                    d.rdy   = 1'b1;
                    d.hsel  = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_WSU: begin
                if (q.cnt == '0) begin
                    d.wrn   = 1'b0;
                    d.state = S_WSTB;
                    d.cnt   = CNT_W'(STB_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_WSTB: begin
                if (q.cnt == '0) begin
                    d.wrn   = 1'b1;
                    d.csn   = 1'b1;
                    d.state = S_WGAP;
                    d.cnt   = CNT_W'(GAP_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_WGAP: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (!q.word && !q.second) begin
                    d.second = 1'b1;
                    d.state  = S_WSU;
                    d.cnt    = CNT_W'(SU_CYC - 1);
                    d.csn    = 1'b0;
                    d.hsel   = 1'b1;
                    d.dout   = {8'h00, q.wdat[11:8]};
                end else begin
                    d.state = S_IDLE;
                    d.rdy   = 1'b1;
                    d.hsel  = 1'b0;
                    d.oe    = 1'b0;
                    d.dout  = '0;
                end
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign conv_start_n = q.cvn;
    assign bus_cs_n     = q.csn;
    assign bus_rd_n     = q.rdn;
    assign bus_wr_n     = q.wrn;
    assign byte_hi_sel  = q.hsel;
    assign bus_oe       = q.oe;
    assign bus_dout     = q.dout;
    assign ready        = q.rdy;
    assign res_valid    = q.vld;
    assign res_data     = q.res;
    assign res_chan     = q.chan;
    assign timeout_err  = q.err;

endmodule

module adc_host_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        conv_start_n,
    input logic        bus_cs_n,
    input logic        bus_rd_n,
    input logic        bus_wr_n,
    input logic        byte_hi_sel,
    input logic        bus_oe,
    input logic [11:0] bus_dout,
    input logic        res_valid,
    input logic        timeout_err,
    input logic        ready,
    input int          stb_cyc
);

    int rd_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_low_cnt <= 0;
        else if (!bus_rd_n) rd_low_cnt <= rd_low_cnt + 1;
        else                rd_low_cnt <= 0;
    end

    // R4
    rd_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_cs_n);

    // R4
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |-> rd_low_cnt >= stb_cyc);

    // R10
    wr_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (bus_oe && !bus_cs_n && bus_rd_n));

    // R3
    start_apart_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start_n |-> (bus_cs_n && bus_oe == 1'b0));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    hsel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || $rose(bus_rd_n) || !bus_wr_n || $rose(bus_wr_n)) |-> $stable(byte_hi_sel));

    // R9
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (conv_start_n && bus_cs_n && ready && !res_valid));

    // R11
    hi_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && byte_hi_sel) |-> (bus_dout[7:4] == 4'h0));

    // R12
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (bus_cs_n && conv_start_n && bus_rd_n && bus_wr_n));

endmodule

bind adc_host_ctrl adc_host_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start_n (conv_start_n),
    .bus_cs_n     (bus_cs_n),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .byte_hi_sel  (byte_hi_sel),
    .bus_oe       (bus_oe),
    .bus_dout     (bus_dout),
    .res_valid    (res_valid),
    .timeout_err  (timeout_err),
    .ready        (ready),
    .stb_cyc      (STB_CYC)
);

// File: tb/test_adc_host_ctrl.sv
`timescale 1ns/1ps
module test_adc_host_ctrl;

    localparam int CLK_PS = 5000;
    localparam int CONV_PS = 12000, SETUP_PS = 0, STB_PS = 30000, GAP_PS = 10000, QUIET_PS = 11000;
    localparam int TMO = 16;
    // cycle counts from the rounding rule (R13)
    localparam int CNV = 3, SU = 1, STB = 6, GAP = 2, Q = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, conv_req, cfg_wr_req, word_mode, cnv_busy;
    logic [11:0] cfg_wr_word, bus_din, bus_dout;
    logic bus_oe, conv_start_n, bus_cs_n, bus_rd_n, bus_wr_n, byte_hi_sel, ready, res_valid, timeout_err;
    logic [11:0] res_data;
    logic [2:0]  res_chan;
    logic [11:0] o10_dout;
    logic o10_oe, o10_cvn, o10_csn, o10_rdn, o10_wrn, o10_hsel, o10_rdy, o10_vld, o10_err;
    logic [9:0] o10_data;
    logic [2:0] o10_chan;

    logic [11:0] cv_res;
    logic [2:0]  cv_chan;

    adc_host_ctrl #(.CLK_PS(CLK_PS), .CONV_LOW_PS(CONV_PS), .SETUP_PS(SETUP_PS), .STROBE_PS(STB_PS),
        .GAP_PS(GAP_PS), .QUIET_PS(QUIET_PS), .BUSY_TMO_CYC(TMO), .RESULT_BITS(12)) i_adc_host_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .cfg_wr_req(cfg_wr_req), .cfg_wr_word(cfg_wr_word),
        .word_mode(word_mode), .cnv_busy(cnv_busy), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .conv_start_n(conv_start_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .byte_hi_sel(byte_hi_sel), .ready(ready), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .timeout_err(timeout_err));

    adc_host_ctrl #(.CLK_PS(CLK_PS), .CONV_LOW_PS(CONV_PS), .SETUP_PS(SETUP_PS), .STROBE_PS(STB_PS),
        .GAP_PS(GAP_PS), .QUIET_PS(QUIET_PS), .BUSY_TMO_CYC(TMO), .RESULT_BITS(10)) i_adc_host_ctrl_10 (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .cfg_wr_req(cfg_wr_req), .cfg_wr_word(cfg_wr_word),
        .word_mode(word_mode), .cnv_busy(cnv_busy), .bus_din(bus_din), .bus_dout(o10_dout), .bus_oe(o10_oe),
        .conv_start_n(o10_cvn), .bus_cs_n(o10_csn), .bus_rd_n(o10_rdn), .bus_wr_n(o10_wrn),
        .byte_hi_sel(o10_hsel), .ready(o10_rdy), .res_valid(o10_vld), .res_data(o10_data),
        .res_chan(o10_chan), .timeout_err(o10_err));

    // converter bus model; junk in unused byte-mode bits
    assign bus_din = (!bus_cs_n && !bus_rd_n)
        ? (word_mode ? cv_res
                     : (byte_hi_sel ? {4'h5, 1'b1, cv_chan, cv_res[11:8]} : {4'h5, cv_res[7:0]}))
        : 12'h000;

    logic e_cvn = 1'b1, e_csn = 1'b1, e_rdn = 1'b1, e_wrn = 1'b1, e_hsel = 1'b0, e_oe = 1'b0;
    logic e_vld = 1'b0, e_err = 1'b0, e_rdy = 1'b1;
    logic [11:0] e_dout = '0, e_res = '0;
    logic [2:0]  e_chan = '0;
    string cur_req = "R1";
    int n_chk = 0, n_fail = 0;
    bit chk_on = 1'b0;

    task automatic cmp(input string nm, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (chk_on) begin
        cmp("conv_start_n", 32'(conv_start_n), 32'(e_cvn));
        cmp("bus_cs_n", 32'(bus_cs_n), 32'(e_csn));
        cmp("bus_rd_n", 32'(bus_rd_n), 32'(e_rdn));
        cmp("bus_wr_n", 32'(bus_wr_n), 32'(e_wrn));
        cmp("byte_hi_sel", 32'(byte_hi_sel), 32'(e_hsel));
        cmp("bus_oe", 32'(bus_oe), 32'(e_oe));
        cmp("bus_dout", 32'(bus_dout), 32'(e_dout));
        cmp("res_valid", 32'(res_valid), 32'(e_vld));
        cmp("timeout_err", 32'(timeout_err), 32'(e_err));
        cmp("ready", 32'(ready), 32'(e_rdy));
        cmp("R8 res_valid_10", 32'(o10_vld), 32'(e_vld));
        if (e_vld) begin
            cmp("res_data", 32'(res_data), 32'(e_res));
            cmp("res_chan", 32'(res_chan), 32'(e_chan));
            cmp("R8 res_data_10", 32'(o10_data), 32'(e_res[11:2]));
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic run_conv(input bit wm, input logic [11:0] r, input logic [2:0] ch,
                            input int hi_dly, input int hi_len, input bit poke);
        int k;
        bit ph;
        word_mode = wm; cv_res = r; cv_chan = ch;
        cur_req = poke ? "R12" : "R2 R13";
        conv_req = 1'b1; cfg_wr_req = poke; cfg_wr_word = 12'hFFF;
        tick;
        conv_req = 1'b0; cfg_wr_req = 1'b0;
        e_cvn = 1'b0; e_rdy = 1'b0;
        cur_req = "R2 R13";
        for (int i = 1; i <= CNV; i++) begin
            tick;
            if (i == CNV) e_cvn = 1'b1;
        end
        cur_req = poke ? "R12" : "R3";
        k = 0; ph = 1'b0;
        forever begin
            cnv_busy = (k >= hi_dly) && (k < hi_dly + hi_len);
            conv_req = poke; cfg_wr_req = poke;
            tick;
            if (!ph && cnv_busy) ph = 1'b1;
            else if (ph && !cnv_busy) break;
            else if (k >= TMO - 1) begin
                cur_req = "R9";
                e_err = 1'b1; e_rdy = 1'b1;
                conv_req = 1'b0; cfg_wr_req = 1'b0; cnv_busy = 1'b0;
                tick;
                e_err = 1'b0;
                return;
            end
            k++;
        end
        conv_req = 1'b0; cfg_wr_req = 1'b0;
        e_csn = 1'b0; e_hsel = 1'b0;
        for (int rd = 0; rd < (wm ? 1 : 2); rd++) begin
            cur_req = "R3 R13";
            for (int i = 1; i <= SU; i++) begin
                tick;
                if (i == SU) e_rdn = 1'b0;
            end
            cur_req = "R4 R13";
            for (int i = 1; i <= STB; i++) begin
                tick;
                if (i == STB) begin e_rdn = 1'b1; e_csn = 1'b1; end
            end
            if (wm || rd == 1) begin
                e_vld = 1'b1; e_res = r; e_chan = wm ? 3'd0 : ch;
                cur_req = wm ? "R5" : "R6";
            end else begin
                cur_req = "R6";
                for (int i = 1; i <= GAP; i++) begin
                    tick;
                    if (i == GAP) begin e_csn = 1'b0; e_hsel = 1'b1; end
                end
            end
        end
        for (int i = 1; i <= Q; i++) begin
            tick;
            if (i == 1) begin e_vld = 1'b0; cur_req = "R7 R13"; end
            if (i == Q) begin e_rdy = 1'b1; e_hsel = 1'b0; end
        end
    endtask

    task automatic run_wr(input bit wm, input logic [11:0] w);
        word_mode = wm; cfg_wr_word = w; cfg_wr_req = 1'b1;
        cur_req = wm ? "R10" : "R11";
        tick;
        cfg_wr_req = 1'b0; cfg_wr_word = ~w;
        e_csn = 1'b0; e_hsel = 1'b0; e_oe = 1'b1; e_rdy = 1'b0;
        e_dout = wm ? w : {4'h0, w[7:0]};
        for (int p = 0; p < (wm ? 1 : 2); p++) begin
            for (int i = 1; i <= SU; i++) begin
                tick;
                if (i == SU) e_wrn = 1'b0;
            end
            for (int i = 1; i <= STB; i++) begin
                tick;
                if (i == STB) begin e_wrn = 1'b1; e_csn = 1'b1; end
            end
            for (int i = 1; i <= GAP; i++) begin
                tick;
                if (i == GAP) begin
                    if (!wm && p == 0) begin
                        e_csn = 1'b0; e_hsel = 1'b1; e_dout = {8'h00, w[11:8]};
                    end else begin
                        e_rdy = 1'b1; e_hsel = 1'b0; e_oe = 1'b0; e_dout = '0;
                    end
                end
            end
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
        summary();
    end

    initial begin
        rst_n = 1'b0; conv_req = 1'b0; cfg_wr_req = 1'b0; cfg_wr_word = '0;
        word_mode = 1'b1; cnv_busy = 1'b0; cv_res = '0; cv_chan = '0;
        chk_on = 1'b1;
        cur_req = "R1";
        repeat (3) tick;
        rst_n = 1'b1;
        repeat (2) tick;
        // word mode reads
        run_conv(1'b1, 12'hA5C, 3'd2, 2, 5, 1'b0);
        run_conv(1'b1, 12'h001, 3'd0, 0, 1, 1'b0);
        // byte mode reads
        run_conv(1'b0, 12'h3E7, 3'd5, 0, 1, 1'b0);
        run_conv(1'b0, 12'hFFF, 3'd7, 4, 3, 1'b0);
        run_conv(1'b0, 12'h800, 3'd1, 1, 2, 1'b0);
        // busy timeouts: never rises, never falls
        run_conv(1'b1, 12'h123, 3'd0, 0, 0, 1'b0);
        run_conv(1'b0, 12'h456, 3'd3, 1, 100, 1'b0);
        // requests while busy, and simultaneous requests
        run_conv(1'b1, 12'h7E1, 3'd0, 3, 4, 1'b1);
        run_conv(1'b0, 12'h0F0, 3'd6, 1, 2, 1'b1);
        // configuration writes
        tick;
        run_wr(1'b1, 12'h9C3);
        run_wr(1'b0, 12'hB7E);
        run_wr(1'b0, 12'h0FF);
        // conversion straight after a write
        run_conv(1'b1, 12'h5AA, 3'd0, 1, 1, 1'b0);
        cur_req = "R12";
        repeat (4) tick;
        summary();
    end

endmodule